// File: doc/BRIEF.md
# Three-Way Dithered PWM Duty Sequencer

The block drives one PWM pin from a free-running period timer and moves the average compare value in steps finer than one timer count. It never holds a single compare value. Over a window of `SL` PWM periods it spends a set number of periods at each of three adjacent compare values, high first, then mid, then low. Each sequence step adds 1/`SL` of a timer count to the average.

A step-up request moves the sequence step on by one, but only when the current window ends. The per-step period counts follow fixed arithmetic rules, so no table is stored. One step in the middle of the sequence runs on two adjacent values, and after that step the roles of the high and low counts swap. When the step index wraps, the whole compare triplet moves up by one count. A control loop that tracks an operating point raises the request whenever it wants a slightly larger duty.

Top module: `tri_dither_pwm`

## Requirements
- R1: On synchronous reset the step index is 0 and the low compare value is `BASE0`. The active compare reads `BASE0+2` and the PWM pin is low.
- R2: The pin goes high at every clock edge where the timer equals its maximum `2**CW-1`. It goes low at an edge where the timer equals the active compare value and is not at its maximum. Otherwise it holds, so a period with compare `c < 2**CW-1` is high for `c+1` clocks.
- R3: The active compare value changes only at clock edges where the timer is at its maximum.
- R4: A window is `SL` consecutive periods, counted from reset. Within it the high value is used for HC periods, then the mid value for MC periods, then the low value for the remaining LC = `SL`-HC-MC periods. In a three-way step with low value L the values are L+2, L+1 and L.
- R5: For step s below `SL/2`, MC is 2 when s is even and 1 when s is odd. HC starts at `SL/2-1` and grows by one at every odd step. LC starts at `SL/2-1` and shrinks by one at every even step from 2 on. The low value equals the base B.
- R6: Step `SL/2` is two-way: HC = LC = `SL/2` and MC = 0, using values B+2 (first half of the window) and B+1.
- R7: For a step above `SL/2` the low value is B+1. The HC and LC of step `SL/2-1` trade places at step `SL/2+1`. From there LC shrinks at each even distance from `SL/2` and HC grows at each odd distance of 3 or more. MC follows the parity rule of R5.
- R8: The compare values of one window sum to `SL*(B+1)+s`, so each step raises the average by 1/`SL` count.
- R9: A request, including one seen on the last clock of a window, takes effect at that window's end. Any number of requests in one window give one step. The step index never changes inside a window.
- R10: Advancing from step `SL-1` gives step 0 and raises the base B by one.
- R11: While B = `CEIL-3` and the step is `SL-1`, where the high value equals `CEIL`, requests are ignored and the state is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_req | input | 1 | Request to raise the average duty by one sequence step |
| tmr_i | input | CW | Free-running PWM period timer, counting 0 to 2**CW-1 |
| pwm_o | output | 1 | PWM pin |
| cmp_o | output | CW | Compare value active in the current period |
| step_o | output | $clog2(SL) | Current sequence step index |

## Verification
The checker covers the relations that hold on every clock. The pin sets at the timer maximum and clears on a compare match. The active compare and the step index move only on a period boundary. The step index only ever advances by one or wraps, and the compare value stays within `CEIL`.

The per-step period counts, the high/mid/low order within a window, and the two-way step with its swap can only be seen over whole windows of bench stimulus. The same holds for the exact window sum, deferred and merged requests, the base increment on wrap, and the ignored requests at the top.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
   // which of the three compare levels a period of the window uses
   typedef enum logic [1:0] {
      LVL_HI  = 2'd0,
      LVL_MID = 2'd1,
      LVL_LO  = 2'd2
   } tdp_lvl_e;
endpackage

// File: rtl/tdp_coef.sv
// Rule-based run-length coefficients for one sequence step.
module tdp_coef #(
   parameter int SL = 8,
   localparam int SW = $clog2(SL),
   localparam int KW = $clog2(SL + 1)
) (
   input  logic [SW-1:0] step_i,
   output logic [KW-1:0] hc_o,
   output logic [KW-1:0] mc_o
);
   localparam int H = SL / 2;

   always_comb begin
      if (int'(step_i) < H) begin
         hc_o = KW'(H - 1 + (int'(step_i) + 1) / 2);
         mc_o = step_i[0] ? KW'(1) : KW'(2);
      end else if (int'(step_i) == H) begin
         hc_o = KW'(H);
         mc_o = KW'(0);
      end else begin
         hc_o = KW'(H / 2 + (int'(step_i) - H - 1) / 2);
         mc_o = step_i[0] ? KW'(1) : KW'(2);
      end
   end
endmodule

// File: rtl/tdp_sel.sv
// Picks the compare value for one period of the window.
module tdp_sel
   import tdp_pkg::*;
#(
   parameter int SL = 8,
   parameter int CW = 5,
   localparam int SW = $clog2(SL),
   localparam int KW = $clog2(SL + 1)
) (
   input  logic [SW-1:0] pc_i,
   input  logic [SW-1:0] step_i,
   input  logic [CW-1:0] base_i,
   input  logic [KW-1:0] hc_i,
   input  logic [KW-1:0] mc_i,
   output logic [CW-1:0] cmp_o
);
   localparam int H = SL / 2;

   tdp_lvl_e      lvl;
   logic [CW-1:0] lo_v;
   logic [CW-1:0] hi_v;

   always_comb begin
      if (KW'(pc_i) < hc_i)             lvl = LVL_HI;
      else if (KW'(pc_i) < hc_i + mc_i) lvl = LVL_MID;
      else                              lvl = LVL_LO;
   end

   always_comb begin
      lo_v = base_i + ((int'(step_i) >= H) ? CW'(1) : CW'(0));
      hi_v = (int'(step_i) == H) ? lo_v + CW'(1) : lo_v + CW'(2);
      unique case (lvl)
         LVL_HI:  cmp_o = hi_v;
         LVL_MID: cmp_o = lo_v + CW'(1);
         default: cmp_o = lo_v;
      endcase
   end
endmodule

// File: rtl/tdp_seq.sv
// Sequence step and base state with deferred step requests.
module tdp_seq #(
   parameter int SL    = 8,
   parameter int CW    = 5,
   parameter int BASE0 = 1,
   parameter int CEIL  = 31,
   localparam int SW = $clog2(SL)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_i,
   input  logic          win_end_i,
   output logic [SW-1:0] step_q_o,
   output logic [CW-1:0] base_q_o,
   output logic [SW-1:0] step_d_o,
   output logic [CW-1:0] base_d_o
);
   localparam logic [SW-1:0] LAST = SW'(SL - 1);
   localparam logic [CW-1:0] BTOP = CW'(CEIL - 3);

   logic [SW-1:0] step_q;
   logic [CW-1:0] base_q;
   logic          pend_q;
   logic          at_top;
   logic          eff;
   logic          adv;

   assign at_top = (base_q == BTOP) && (step_q == LAST);
   assign eff    = pend_q | req_i;
   assign adv    = win_end_i & eff & ~at_top;

   assign step_d_o = adv ? ((step_q == LAST) ? '0 : step_q + SW'(1)) : step_q;
   assign base_d_o = (adv && step_q == LAST) ? base_q + CW'(1) : base_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= '0;
         base_q <= CW'(BASE0);
         pend_q <= 1'b0;
      end else begin
         step_q <= step_d_o;
         base_q <= base_d_o;
         pend_q <= win_end_i ? 1'b0 : (eff & ~at_top);
      end
   end

   assign step_q_o = step_q;
   assign base_q_o = base_q;
endmodule

// File: rtl/tri_dither_pwm.sv
// Three-way dithered PWM: period window counter, compare register, pin.
module tri_dither_pwm #(
   parameter int CW    = 5,
   parameter int SL    = 8,
   parameter int BASE0 = 1,
   parameter int CEIL  = 31,
   localparam int SW = $clog2(SL),
   localparam int KW = $clog2(SL + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_req,
   input  logic [CW-1:0] tmr_i,
   output logic          pwm_o,
   output logic [CW-1:0] cmp_o,
   output logic [SW-1:0] step_o
);
   localparam logic [CW-1:0] TMAX = '1;
   localparam logic [SW-1:0] LAST = SW'(SL - 1);

   generate
      if (SL < 4 || SL % 4 != 0) begin : g_bad_sl
         $error("tri_dither_pwm: SL must be a multiple of 4, at least 4");
      end
      if (CEIL > (1 << CW) - 1 || BASE0 + 3 > CEIL || BASE0 < 0) begin : g_bad_range
         $error("tri_dither_pwm: need 0 <= BASE0, BASE0+3 <= CEIL <= 2**CW-1");
      end
   endgenerate

   logic [SW-1:0] pc_q;
   logic [SW-1:0] pc_d;
   logic [CW-1:0] cmp_q;
   logic [CW-1:0] cmp_d;
   logic          pwm_q;
   logic          bnd;
   logic          win_end;
   logic [SW-1:0] step_q;
   logic [SW-1:0] step_d;
   logic [CW-1:0] base_q;
   logic [CW-1:0] base_d;
   logic [KW-1:0] hc;
   logic [KW-1:0] mc;

   assign bnd     = (tmr_i == TMAX);
   assign win_end = bnd && (pc_q == LAST);
   assign pc_d    = bnd ? ((pc_q == LAST) ? '0 : pc_q + SW'(1)) : pc_q;

   tdp_seq #(.SL(SL), .CW(CW), .BASE0(BASE0), .CEIL(CEIL)) i_seq (
      .clk       (clk),
      .rst       (rst),
      .req_i     (step_req),
      .win_end_i (win_end),
      .step_q_o  (step_q),
      .base_q_o  (base_q),
      .step_d_o  (step_d),
      .base_d_o  (base_d)
   );

   tdp_coef #(.SL(SL)) i_coef (
      .step_i (step_d),
      .hc_o   (hc),
      .mc_o   (mc)
   );

   tdp_sel #(.SL(SL), .CW(CW)) i_sel (
      .pc_i   (pc_d),
      .step_i (step_d),
      .base_i (base_d),
      .hc_i   (hc),
      .mc_i   (mc),
      .cmp_o  (cmp_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         cmp_q <= CW'(BASE0 + 2);
         pwm_q <= 1'b0;
      end else if (bnd) begin
         pc_q  <= pc_d;
         cmp_q <= cmp_d;
         pwm_q <= 1'b1;
      end else if (tmr_i == cmp_q) begin
         pwm_q <= 1'b0;
      end
   end

   assign pwm_o  = pwm_q;
   assign cmp_o  = cmp_q;
   assign step_o = step_q;
endmodule

// File: rtl/tdp_chk.sv
// Cycle-level checks on the ports of tri_dither_pwm.
module tdp_chk #(
   parameter int CW   = 5,
   parameter int SL   = 8,
   parameter int CEIL = 31,
   localparam int SW = $clog2(SL)
) (
   input logic          clk,
   input logic          rst,
   input logic [CW-1:0] tmr_i,
   input logic          pwm_o,
   input logic [CW-1:0] cmp_o,
   input logic [SW-1:0] step_o
);
   localparam logic [CW-1:0] TMAX = '1;
   localparam logic [SW-1:0] LAST = SW'(SL - 1);

   // R2
   pwm_set_chk: assert property (@(posedge clk) disable iff (rst)
      (tmr_i == TMAX) |=> pwm_o);

   // R2
   pwm_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (tmr_i != TMAX && tmr_i == cmp_o) |=> !pwm_o);

   // R3
   cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (tmr_i != TMAX) |=> $stable(cmp_o));

   // R9
   step_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (tmr_i != TMAX) |=> $stable(step_o));

   // R10
   step_move_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(step_o) |->
         (step_o == $past(step_o) + SW'(1)) || (step_o == '0 && $past(step_o) == LAST));

   // R11
   cmp_ceil_chk: assert property (@(posedge clk) disable iff (rst)
      cmp_o <= CW'(CEIL));
endmodule

bind tri_dither_pwm tdp_chk #(.CW(CW), .SL(SL), .CEIL(CEIL)) i_tdp_chk (
   .clk    (clk),
   .rst    (rst),
   .tmr_i  (tmr_i),
   .pwm_o  (pwm_o),
   .cmp_o  (cmp_o),
   .step_o (step_o)
);

// File: tb/test_tri_dither_pwm.sv
module test_tri_dither_pwm;
   localparam int CW    = 5;
   localparam int SL    = 8;
   localparam int BASE0 = 1;
   localparam int CEIL  = 31;
   localparam int SW    = $clog2(SL);
   localparam int H     = SL / 2;
   localparam int TMAX  = (1 << CW) - 1;
   localparam int PER   = TMAX + 1;
   localparam int WIN   = SL * PER;

   logic          clk = 1'b0;
   logic          rst;
   logic          step_req;
   logic [CW-1:0] tmr_i;
   logic          pwm_o;
   logic [CW-1:0] cmp_o;
   logic [SW-1:0] step_o;

   int n_chk  = 0;
   int n_fail = 0;
   int ex_s;
   int ex_b;
   int ex_pwm;
   bit wrapped;

   always #4 clk = ~clk;

   tri_dither_pwm #(.CW(CW), .SL(SL), .BASE0(BASE0), .CEIL(CEIL)) i_tri_dither_pwm (
      .clk      (clk),
      .rst      (rst),
      .step_req (step_req),
      .tmr_i    (tmr_i),
      .pwm_o    (pwm_o),
      .cmp_o    (cmp_o),
      .step_o   (step_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // coefficients by walking the update rules step by step
   function automatic void exp_coef(input int s, output int hc, output int mc);
      int h = H - 1;
      int l = H - 1;
      int t;
      mc = (s % 2 != 0) ? 1 : 2;
      if (s == H) begin
         hc = H;
         mc = 0;
         return;
      end
      for (int i = 1; i <= s && i < H; i++) begin
         if (i % 2 != 0) h++;
         else            l--;
      end
      if (s > H) begin
         t = h; h = l; l = t;
         for (int k = 2; k <= s - H; k++) begin
            if (k % 2 != 0) h++;
            else            l--;
         end
      end
      hc = h;
   endfunction

   function automatic int exp_cmp(input int s, input int b, input int p);
      int hc, mc, lo;
      exp_coef(s, hc, mc);
      if (s == H) return (p < hc) ? b + 2 : b + 1;
      lo = (s > H) ? b + 1 : b;
      if (p < hc)      return lo + 2;
      if (p < hc + mc) return lo + 1;
      return lo;
   endfunction

   function automatic bit at_top();
      return (ex_b == CEIL - 3) && (ex_s == SL - 1);
   endfunction

   // one window of SL periods; up to two request pulses at given clock indices
   task automatic run_window(input int nreq, input int pa, input int pb);
      int seen [SL];
      int sum = 0;
      int bad;
      int cur;
      int tagok = 1;
      string tg;
      for (int p = 0; p < SL; p++) begin
         bad = 0;
         cur = int'(cmp_o);
         seen[p] = cur;
         // R9: step index fixed inside the window
         check(int'(step_o) == ex_s, "R9 step index", int'(step_o), ex_s);
         for (int t = 0; t < PER; t++) begin
            tmr_i = CW'(t);
            step_req = (nreq >= 1 && p * PER + t == pa) || (nreq >= 2 && p * PER + t == pb);
            if (t == TMAX)     ex_pwm = 1;
            else if (t == cur) ex_pwm = 0;
            @(negedge clk);
            if (int'(pwm_o) != ex_pwm) bad++;
            if (t != TMAX && int'(cmp_o) != cur) bad++;
         end
         // R2 R3: pin edges and compare stability over the period
         check(bad == 0, "R2 R3 period waveform", bad, 0);
      end
      step_req = 1'b0;
      tg = (ex_s == H) ? "R6 two-way step" : (ex_s > H) ? "R7 after swap" : "R5 before swap";
      for (int p = 0; p < SL; p++) begin
         sum += seen[p];
         if (seen[p] != exp_cmp(ex_s, ex_b, p)) begin
            if (tagok) check(0, {"R4 ", tg}, seen[p], exp_cmp(ex_s, ex_b, p));
            tagok = 0;
         end
      end
      if (tagok) check(1, {"R4 ", tg}, 0, 0);
      // R8: window sum
      check(sum == SL * (ex_b + 1) + ex_s, "R8 window sum", sum, SL * (ex_b + 1) + ex_s);
      if (wrapped) begin
         // R10: first period after wrap uses the raised base
         check(seen[0] == ex_b + 2, "R10 wrap raises base", seen[0], ex_b + 2);
         wrapped = 0;
      end
      if (nreq > 0 && !at_top()) begin
         if (ex_s == SL - 1) begin
            ex_s = 0;
            ex_b++;
            wrapped = 1;
         end else begin
            ex_s++;
         end
      end
   endtask

   initial begin
      #(190000 * 8);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      int guard;
      int keep_s;
      int keep_b;
      void'($urandom(32'd5273));
      rst = 1'b1;
      step_req = 1'b0;
      tmr_i = '0;
      ex_s = 0;
      ex_b = BASE0;
      ex_pwm = 0;
      wrapped = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(step_o == '0, "R1 step after reset", int'(step_o), 0);
      check(int'(cmp_o) == BASE0 + 2, "R1 compare after reset", int'(cmp_o), BASE0 + 2);
      check(pwm_o == 1'b0, "R1 pin after reset", int'(pwm_o), 0);
      rst = 1'b0;

      // R9: no request, no step
      run_window(0, 0, 0);
      check(ex_s == 0 && int'(step_o) == 0, "R9 idle window keeps step", int'(step_o), 0);
      // R9: request in the middle of a window
      run_window(1, WIN / 2 + 5, 0);
      check(int'(step_o) == 1, "R9 deferred request", int'(step_o), 1);
      // R9: two requests in one window give one step
      run_window(2, 3, WIN - 40);
      check(int'(step_o) == 2, "R9 merged requests", int'(step_o), 2);
      // R9: request on the last clock of the window
      run_window(1, WIN - 1, 0);
      check(int'(step_o) == 3, "R9 request on window end", int'(step_o), 3);

      // random walk up to the top of the range
      guard = 0;
      while (!at_top() && guard < 600) begin
         if ($urandom_range(0, 99) < 85)
            run_window(1, $urandom_range(0, WIN - 1), 0);
         else
            run_window(0, 0, 0);
         guard++;
      end
      check(at_top(), "R10 top reached", ex_b, CEIL - 3);

      // R11: requests ignored at the top
      keep_s = ex_s;
      keep_b = ex_b;
      run_window(2, 10, WIN - 1);
      run_window(1, $urandom_range(0, WIN - 1), 0);
      check(int'(step_o) == keep_s, "R11 step kept at top", int'(step_o), keep_s);
      run_window(0, 0, 0);
      check(ex_b == keep_b, "R11 base kept at top", ex_b, keep_b);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule